// File: doc/BRIEF.md
# UART Bit-Timing Generator with Fine Adjust

This block derives the timing strobes for one serial UART channel from its operating clock. A coarse 8-bit divider sets how many clocks each sampling tick lasts. An oversampling select chooses 16 or 4 sampling ticks per bit. A 4-bit fine-adjust value lengthens every bit by a few whole clocks, and these extra clocks are added to the last sampling tick of the bit. The block outputs a sampling strobe, a strobe that marks the end of each bit, and a strobe at the middle of the bit that a receiver can use to take its data sample.

The divider, fine-adjust and ratio inputs are captured only at bit boundaries, so a bit that has started always completes with the settings it started with. Dropping `enable` clears all counters. Raising it again starts a new bit from zero, which lets a receiver line the bit grid up with a start-bit edge. While the CPU is halted for debug, a run-in-debug control decides what happens. The generator either freezes with every counter and output held, or keeps counting. After a freeze it continues from exactly where it stopped.

The sequencer has three states. `ST_IDLE` holds everything cleared while `enable` is low. `ST_COUNT` divides down sampling ticks and advances the tick index. `ST_STRETCH` adds the fine-adjust clocks after the last tick of a bit. The transitions are:
- IDLE→COUNT (start): `enable` is high and the block is not frozen.
- COUNT→COUNT (tick, or bit end when fine-adjust is 0).
- COUNT→STRETCH (last tick done, fine-adjust not 0).
- STRETCH→COUNT (bit end).
- any→IDLE: `enable` falls.
- Every state holds (freeze) while the block is frozen.

Top module: `uart_bitclk_gen`

## Requirements
- R1: After reset, `sample_tick`, `bit_tick` and `mid_tick` are all 0.
- R2: While running, consecutive `sample_tick` pulses within a bit are `div_val`+1 clock cycles apart. Each pulse lasts one cycle.
- R3: With `os_sel`=0 a bit has 16 sampling ticks, and with `os_sel`=1 it has 4. `bit_tick` pulses for one cycle, together with the last `sample_tick` of the bit.
- R4: The last sampling tick of a bit lasts `div_val`+1+`fine_adj` cycles, so a bit lasts (`div_val`+1)×ratio+`fine_adj` cycles.
- R5: `mid_tick` pulses together with sampling tick number ratio/2 of each bit (counting from 1). It never coincides with `bit_tick`.
- R6: While `enable`=1, `debug_active`=1 and `dbrun`=0, all three outputs hold their values from cycle to cycle.
- R7: When the freeze ends, counting resumes from the held state. The bit in progress is lengthened by exactly the number of frozen cycles.
- R8: With `dbrun`=1, `debug_active` has no effect on the timing.
- R9: While `enable`=0 all outputs are 0. Once `enable` is sampled high on a clock edge, the first `sample_tick` follows `div_val`+1 edges later.
- R10: Changes to `div_val`, `fine_adj` or `os_sel` take effect only at the start of the next bit. The settings are captured on the edge that produces `bit_tick`, or on the start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Operating clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run the generator; low clears all state |
| div_val | input | 8 | Coarse divider; a sampling tick lasts div_val+1 clocks |
| fine_adj | input | 4 | Extra clocks added to each bit |
| os_sel | input | 1 | Oversampling: 0 = 16 ticks per bit, 1 = 4 |
| debug_active | input | 1 | CPU is in debug state |
| dbrun | input | 1 | 1 = keep running in debug, 0 = freeze |
| sample_tick | output | 1 | Sampling strobe |
| bit_tick | output | 1 | End-of-bit strobe |
| mid_tick | output | 1 | Mid-bit strobe |

## Verification
The bound checker checks the following on every cycle:
- outputs stay quiet while the block is disabled;
- `bit_tick` and `mid_tick` only appear together with a sampling strobe, and never with each other;
- `bit_tick` lasts one cycle;
- all outputs are frozen while debug holds the block.

The cycle counts need the bench's scenarios:
- spacing between ticks;
- the lengthened last tick;
- the position of the mid strobe;
- the lengthening of a bit by a freeze;
- the delay to the first tick after enable;
- deferral of new settings to the next bit.

// File: rtl/uart_btg_pkg.sv
package uart_btg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COUNT   = 2'd1,
        ST_STRETCH = 2'd2
    } seq_state_e;

endpackage

// File: rtl/uart_btg_cfg.sv
// Shadow registers for the timing settings, loaded only at bit boundaries.
module uart_btg_cfg #(
    parameter int DIV_W  = 8,
    parameter int FINE_W = 4,
    parameter int OS_HI  = 16,
    parameter int OS_LO  = 4,
    localparam int IDX_W = $clog2(OS_HI)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DIV_W-1:0]  div_in,
    input  logic [FINE_W-1:0] fine_in,
    input  logic              os_in,
    output logic [DIV_W-1:0]  div_q,
    output logic [FINE_W-1:0] fine_q,
    output logic [IDX_W-1:0]  last_idx_q,
    output logic [IDX_W-1:0]  mid_idx_q
);

    localparam logic [IDX_W-1:0] LAST_HI = IDX_W'(OS_HI - 1);
    localparam logic [IDX_W-1:0] LAST_LO = IDX_W'(OS_LO - 1);
    localparam logic [IDX_W-1:0] MID_HI  = IDX_W'(OS_HI / 2 - 1);
    localparam logic [IDX_W-1:0] MID_LO  = IDX_W'(OS_LO / 2 - 1);

    logic [IDX_W-1:0] last_sel;
    logic [IDX_W-1:0] mid_sel;

    always_comb begin
        last_sel = os_in ? LAST_LO : LAST_HI;
        mid_sel  = os_in ? MID_LO  : MID_HI;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q      <= '0;
            fine_q     <= '0;
            last_idx_q <= LAST_HI;
            mid_idx_q  <= MID_HI;
        end else if (load) begin
            div_q      <= div_in;
            fine_q     <= fine_in;
            last_idx_q <= last_sel;
            mid_idx_q  <= mid_sel;
        end
    end

endmodule

// File: rtl/uart_btg_seq.sv
// Tick sequencer: coarse divider, tick index and fine-adjust stretch.
module uart_btg_seq
    import uart_btg_pkg::*;
#(
    parameter int DIV_W  = 8,
    parameter int FINE_W = 4,
    parameter int OS_HI  = 16,
    localparam int IDX_W = $clog2(OS_HI)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              run,
    input  logic [DIV_W-1:0]  div_q,
    input  logic [FINE_W-1:0] fine_q,
    input  logic [IDX_W-1:0]  last_idx_q,
    input  logic [IDX_W-1:0]  mid_idx_q,
    output logic              load_cfg,
    output logic              sample_tick,
    output logic              bit_tick,
    output logic              mid_tick
);

    seq_state_e        state_q, state_d;
    logic [DIV_W-1:0]  div_cnt_q, div_cnt_d;
    logic [IDX_W-1:0]  idx_q, idx_d;
    logic [FINE_W-1:0] ext_q, ext_d;
    logic              smp_d, bit_d, mid_d;

    always_comb begin
        state_d   = state_q;
        div_cnt_d = div_cnt_q;
        idx_d     = idx_q;
        ext_d     = ext_q;
        smp_d     = sample_tick;
        bit_d     = bit_tick;
        mid_d     = mid_tick;
        load_cfg  = 1'b0;
        if (!enable) begin
            state_d   = ST_IDLE;
            div_cnt_d = '0;
            idx_d     = '0;
            ext_d     = '0;
            smp_d     = 1'b0;
            bit_d     = 1'b0;
            mid_d     = 1'b0;
        end else if (run) begin
            smp_d = 1'b0;
            bit_d = 1'b0;
            mid_d = 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    state_d   = ST_COUNT;
                    div_cnt_d = '0;
                    idx_d     = '0;
                    ext_d     = '0;
                    load_cfg  = 1'b1;
                end
                ST_COUNT: begin
                    if (div_cnt_q == div_q) begin
                        div_cnt_d = '0;
                        if (idx_q == last_idx_q) begin
                            if (fine_q == '0) begin
                                smp_d    = 1'b1;
                                bit_d    = 1'b1;
                                idx_d    = '0;
                                load_cfg = 1'b1;
                            end else begin
                                state_d = ST_STRETCH;
                                ext_d   = '0;
                            end
                        end else begin
                            smp_d = 1'b1;
                            mid_d = (idx_q == mid_idx_q);
                            idx_d = idx_q + 1'b1;
                        end
                    end else begin
                        div_cnt_d = div_cnt_q + 1'b1;
                    end
                end
                ST_STRETCH: begin
                    if (ext_q == fine_q - 1'b1) begin
                        smp_d    = 1'b1;
                        bit_d    = 1'b1;
                        idx_d    = '0;
                        ext_d    = '0;
                        state_d  = ST_COUNT;
                        load_cfg = 1'b1;
                    end else begin
                        ext_d = ext_q + 1'b1;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State and counter registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            div_cnt_q <= '0;
            idx_q     <= '0;
            ext_q     <= '0;
        end else begin
            state_q   <= state_d;
            div_cnt_q <= div_cnt_d;
            idx_q     <= idx_d;
            ext_q     <= ext_d;
        end
    end

    // Output strobe registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sample_tick <= 1'b0;
            bit_tick    <= 1'b0;
            mid_tick    <= 1'b0;
        end else begin
            sample_tick <= smp_d;
            bit_tick    <= bit_d;
            mid_tick    <= mid_d;
        end
    end

endmodule

// File: rtl/uart_bitclk_gen.sv
module uart_bitclk_gen #(
    parameter int DIV_W  = 8,
    parameter int FINE_W = 4,
    parameter int OS_HI  = 16,
    parameter int OS_LO  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [DIV_W-1:0]  div_val,
    input  logic [FINE_W-1:0] fine_adj,
    input  logic              os_sel,
    input  logic              debug_active,
    input  logic              dbrun,
    output logic              sample_tick,
    output logic              bit_tick,
    output logic              mid_tick
);

    localparam int IDX_W = $clog2(OS_HI);

    logic              run;
    logic              load_cfg;
    logic [DIV_W-1:0]  div_q;
    logic [FINE_W-1:0] fine_q;
    logic [IDX_W-1:0]  last_idx_q;
    logic [IDX_W-1:0]  mid_idx_q;

    // Frozen when the CPU is in debug and running in debug is not allowed
    assign run = enable && !(debug_active && !dbrun);

    uart_btg_cfg #(
        .DIV_W (DIV_W),
        .FINE_W(FINE_W),
        .OS_HI (OS_HI),
        .OS_LO (OS_LO)
    ) i_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load_cfg),
        .div_in    (div_val),
        .fine_in   (fine_adj),
        .os_in     (os_sel),
        .div_q     (div_q),
        .fine_q    (fine_q),
        .last_idx_q(last_idx_q),
        .mid_idx_q (mid_idx_q)
    );

    uart_btg_seq #(
        .DIV_W (DIV_W),
        .FINE_W(FINE_W),
        .OS_HI (OS_HI)
    ) i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .run        (run),
        .div_q      (div_q),
        .fine_q     (fine_q),
        .last_idx_q (last_idx_q),
        .mid_idx_q  (mid_idx_q),
        .load_cfg   (load_cfg),
        .sample_tick(sample_tick),
        .bit_tick   (bit_tick),
        .mid_tick   (mid_tick)
    );

endmodule

// File: rtl/uart_bitclk_chk.sv
module uart_bitclk_chk (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic debug_active,
    input logic dbrun,
    input logic sample_tick,
    input logic bit_tick,
    input logic mid_tick
);

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!sample_tick && !bit_tick && !mid_tick));

    p_bit_with_sample_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> sample_tick);

    p_bit_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && enable && !(debug_active && !dbrun)) |=> !bit_tick);

    p_mid_with_sample_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mid_tick |-> sample_tick);

    p_mid_not_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> !mid_tick);

    p_freeze_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && debug_active && !dbrun) |=>
            ($stable(sample_tick) && $stable(bit_tick) && $stable(mid_tick)));

endmodule

bind uart_bitclk_gen uart_bitclk_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .debug_active(debug_active),
    .dbrun       (dbrun),
    .sample_tick (sample_tick),
    .bit_tick    (bit_tick),
    .mid_tick    (mid_tick)
);

// File: tb/test_uart_bitclk_gen.sv
`timescale 1ns/1ps
module test_uart_bitclk_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic [7:0] div_val = '0;
    logic [3:0] fine_adj = '0;
    logic       os_sel = 1'b0;
    logic       debug_active = 1'b0;
    logic       dbrun = 1'b0;
    logic       sample_tick, bit_tick, mid_tick;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    uart_bitclk_gen i_uart_bitclk_gen (
        .clk(clk), .rst_n(rst_n), .enable(enable), .div_val(div_val),
        .fine_adj(fine_adj), .os_sel(os_sel), .debug_active(debug_active),
        .dbrun(dbrun), .sample_tick(sample_tick), .bit_tick(bit_tick),
        .mid_tick(mid_tick)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d expected 0", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    // Counts negedges until the sampling strobe (sel 0) or bit strobe (sel 1) is seen
    task automatic wait_for(input int sel, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!((sel == 0) ? sample_tick : bit_tick) && n < 20000);
    endtask

    // Starts at a negedge where bit_tick was seen; measures one whole bit
    task automatic measure_bit(input int gap_exp, output int ticks, output int midpos,
                               output int bad_gap, output int last_gap, output int total);
        int n;
        ticks = 0; midpos = 0; bad_gap = 0; last_gap = 0; total = 0;
        forever begin
            wait_for(0, n);
            total += n;
            ticks++;
            if (mid_tick) midpos = ticks;
            if (bit_tick || ticks > 64) begin
                last_gap = n;
                break;
            end
            if (n != gap_exp) bad_gap++;
        end
    endtask

    task automatic start(input int dv, input int fa, input int os);
        @(negedge clk);
        enable = 1'b0;
        div_val = 8'(dv); fine_adj = 4'(fa); os_sel = os[0];
        @(negedge clk);
        enable = 1'b1;
    endtask

    task automatic t_reset();
        check("R1 sample_tick after reset", sample_tick, 0);
        check("R1 bit_tick after reset", bit_tick, 0);
        check("R1 mid_tick after reset", mid_tick, 0);
    endtask

    task automatic t_pattern(input int dv, input int fa, input int os);
        int n, ticks, midpos, bad, lastg, total, ratio;
        ratio = os ? 4 : 16;
        start(dv, fa, os);
        wait_for(1, n);
        measure_bit(dv + 1, ticks, midpos, bad, lastg, total);
        check("R2 uneven tick gaps", bad, 0);
        check("R3 ticks per bit", ticks, ratio);
        check("R4 last tick length", lastg, dv + 1 + fa);
        check("R4 bit length", total, (dv + 1) * ratio + fa);
        check("R5 mid strobe position", midpos, ratio / 2);
    endtask

    task automatic t_enable();
        int n;
        start(5, 0, 0);
        wait_for(0, n);
        check("R9 first tick after enable", n, 5 + 2);
        repeat (3) @(negedge clk);
        enable = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (i > 0) check("R9 outputs quiet while disabled",
                             {sample_tick, bit_tick, mid_tick}, 0);
        end
        enable = 1'b1;
        wait_for(0, n);
        check("R9 fresh start after re-enable", n, 5 + 2);
    endtask

    task automatic t_debug(input logic run_bit);
        int n, bad;
        logic [2:0] held;
        start(3, 2, 1);
        wait_for(1, n);
        @(negedge clk);
        debug_active = 1'b1;
        dbrun = run_bit;
        held = {sample_tick, bit_tick, mid_tick};
        bad = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (!run_bit && {sample_tick, bit_tick, mid_tick} != held) bad++;
        end
        debug_active = 1'b0;
        dbrun = 1'b0;
        wait_for(1, n);
        if (!run_bit) begin
            check("R6 outputs held during freeze", bad, 0);
            check("R7 bit lengthened by freeze", 1 + 40 + n, 18 + 40);
        end else begin
            check("R8 dbrun keeps timing", (1 + 40 + n) % 18, 0);
        end
    endtask

    task automatic t_cfg_change();
        int n, ticks, midpos, bad, lastg, total;
        start(3, 0, 1);
        wait_for(1, n);
        div_val = 8'd1;
        os_sel = 1'b0;
        fine_adj = 4'd3;
        measure_bit(4, ticks, midpos, bad, lastg, total);
        check("R10 bit in progress keeps old length", total, 16);
        check("R10 bit in progress keeps old ratio", ticks, 4);
        measure_bit(2, ticks, midpos, bad, lastg, total);
        check("R10 next bit uses new settings", total, 2 * 16 + 3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_pattern(2, 0, 0);
        t_pattern(0, 5, 1);
        t_pattern(255, 15, 1);
        t_pattern(1, 7, 0);
        t_enable();
        t_debug(1'b0);
        t_debug(1'b1);
        t_cfg_change();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule